// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block moves a processor clock from its present rate to a new one without software stepping through the change. A request carries four values: the target rate in kHz, the rate the parent PLL should run at when the clock goes up, and two divider configuration words. The block compares the target with the current parent rate it is given. It then runs a fixed series of register accesses on a simple single-master bus to the clock-control block, and one handshake with the parent-PLL control port. The order of that series depends on the direction of the change. While the PLL is retuned, the core runs from an alternate mux input. Each register write is followed by status polling until the hardware confirms the write. Each wait has a programmable limit, and the sequence aborts with an error pulse when a limit runs out.

States and transitions. From `S_IDLE`, an accepted request goes to `S_FINISH` when the target equals the parent rate. It goes to `S_PARK_RD` when the target is lower and to `S_DIV0_WR` when it is higher. Parking runs `S_PARK_RD` → `S_PARK_WR` → `S_PARK_POLL` → `S_PLL`. After the PLL handshake, a decrease continues to `S_DIV0_WR` and an increase continues to `S_REL_RD`. The divider steps run `S_DIV0_WR` → `S_DIV0_POLL` → `S_DIV1_WR` → `S_DIV1_POLL`. From there a decrease goes on to `S_REL_RD` and an increase goes on to `S_PARK_RD`. Release runs `S_REL_RD` → `S_REL_WR` → `S_REL_POLL` → `S_FINISH`. Any poll state, or `S_PLL`, goes to `S_ABORT` when its wait expires. `S_FINISH` and `S_ABORT` both return to `S_IDLE` after one cycle.

A separate combinational port rounds a queried rate against a descending rate table of kHz entries.

Top module: `cpuclk_rate_seq`

## Requirements
- R1: When the accepted target equals `cur_parent_khz`, `done` pulses in the cycle after acceptance, and there is no bus transaction and no PLL request.
- R2: On a decrease (target below `cur_parent_khz`), the writes and the PLL request occur in this order: park write, PLL request at the target rate, divider word 0, divider word 1, release write.
- R3: On an increase, the order is: divider word 0, divider word 1, park write, PLL request at `req_parent_khz`, release write.
- R4: Divider word 1 is written only after a read of divider status 0 has returned zero following the divider word 0 write. The sequence continues past divider status 1 only once that register reads zero.
- R5: Every park write is followed by polling of mux status bits [18:16] until they read 2, and the PLL is requested only after that. The sequence ends with a release write that clears bit 16, and it completes only after bits [18:16] read 1.
- R6: The park and release writes read the mux-select register first and then write back the read value with only bit 16 set (park) or cleared (release).
- R7: Addresses are mux select 0x000, mux status 0x200, divider word 0 at 0x300, divider word 1 at 0x304, divider status 0 at 0x400 and divider status 1 at 0x404. Address, direction and write data stay stable while `bus_req` waits for `bus_ack`.
- R8: `rounded_khz` is the first entry of `table_khz` (entry i at bits [i*FW +: FW], in descending order) that is less than or equal to `query_khz`, or the last entry if no entry qualifies.
- R9: If a poll read returns an unmatched value after at least `poll_limit` cycles in that poll state, or the PLL acknowledge has not come after `poll_limit` cycles, `err` pulses for one cycle and the block returns to idle with no further writes.
- R10: `busy` rises in the cycle after a request is accepted and falls in the cycle after `done` or `err`. A `req_valid` while busy is ignored. Outside busy there is no bus or PLL request.
- R11: `done` and `err` are single-cycle pulses and never high together.
- R12: `pll_req` stays high with a stable `pll_khz` until `pll_ack`, and it is never high together with `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_khz | input | FW | Target CPU clock rate in kHz |
| req_parent_khz | input | FW | Parent rate used when rate goes up |
| req_div0 | input | DW | Divider configuration word 0 |
| req_div1 | input | DW | Divider configuration word 1 |
| cur_parent_khz | input | FW | Present parent PLL rate |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout abort pulse |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register offset |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with ack |
| bus_ack | input | 1 | Transaction complete |
| pll_req | output | 1 | Parent retune request |
| pll_khz | output | FW | Requested parent rate |
| pll_ack | input | 1 | Retune complete |
| poll_limit | input | TW | Wait limit in cycles |
| table_khz | input | NUM_ENT*FW | Descending rate table |
| query_khz | input | FW | Rate to round |
| rounded_khz | output | FW | Rounded rate |

## Verification
The assertions rely on the bus target holding each transaction open until it raises `bus_ack` for exactly one cycle. They rely on `pll_ack` coming only while `pll_req` is high, and on `poll_limit` staying constant during a sequence. The bench models a clock-control block that acknowledges after a random delay of zero to two cycles and drops each acknowledge after one cycle. In that model the status registers settle after random delays, the PLL answers only to an open request, and the limit changes only between requests. A stuck-status mode drives the timeout path. A second strobe is injected while a sequence is running.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PARK_RD,
        S_PARK_WR,
        S_PARK_POLL,
        S_PLL,
        S_DIV0_WR,
        S_DIV0_POLL,
        S_DIV1_WR,
        S_DIV1_POLL,
        S_REL_RD,
        S_REL_WR,
        S_REL_POLL,
        S_FINISH,
        S_ABORT
    } seq_state_e;

    // Clock-control register offsets
    localparam int unsigned OFS_MUX_SEL  = 'h000;
    localparam int unsigned OFS_MUX_STAT = 'h200;
    localparam int unsigned OFS_DIV0     = 'h300;
    localparam int unsigned OFS_DIV1     = 'h304;
    localparam int unsigned OFS_DSTAT0   = 'h400;
    localparam int unsigned OFS_DSTAT1   = 'h404;

    // Mux select / status fields
    localparam int unsigned PARK_BIT     = 16;
    localparam int unsigned MSTAT_LSB    = 16;
    localparam int unsigned MSTAT_W      = 3;
    localparam int unsigned MSTAT_PARKED = 2;
    localparam int unsigned MSTAT_MAIN   = 1;

endpackage

// File: rtl/cpuclk_freq_round.sv
module cpuclk_freq_round #(
    parameter int NUM_ENT = 8,
    parameter int FW      = 32
) (
    input  logic [NUM_ENT*FW-1:0] table_khz,
    input  logic [FW-1:0]         query_khz,
    output logic [FW-1:0]         rounded_khz
);

    logic [FW-1:0]      entry [NUM_ENT];
    logic [NUM_ENT-1:0] fits;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign entry[g] = table_khz[g*FW +: FW];
        assign fits[g]  = (query_khz >= entry[g]);
    end

    // Lowest qualifying index wins; fall back to the last entry.
    always_comb begin
        rounded_khz = entry[NUM_ENT-1];
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (fits[i]) rounded_khz = entry[i];
        end
    end

endmodule

// File: rtl/cpuclk_poll_timer.sv
module cpuclk_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != {TW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/cpuclk_seq_fsm.sv
module cpuclk_seq_fsm
    import cpuclk_seq_pkg::*;
#(
    parameter int FW = 32,
    parameter int DW = 32,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [FW-1:0] req_khz,
    input  logic [FW-1:0] req_parent_khz,
    input  logic [DW-1:0] req_div0,
    input  logic [DW-1:0] req_div1,
    input  logic [FW-1:0] cur_parent_khz,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          pll_ack,
    input  logic          tmo_expired,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          pll_req,
    output logic [FW-1:0] pll_khz,
    output logic          tmr_run,
    output logic          tmr_clr
);

    localparam logic [AW-1:0] A_MSEL  = AW'(OFS_MUX_SEL);
    localparam logic [AW-1:0] A_MSTAT = AW'(OFS_MUX_STAT);
    localparam logic [AW-1:0] A_DIV0  = AW'(OFS_DIV0);
    localparam logic [AW-1:0] A_DIV1  = AW'(OFS_DIV1);
    localparam logic [AW-1:0] A_DST0  = AW'(OFS_DSTAT0);
    localparam logic [AW-1:0] A_DST1  = AW'(OFS_DSTAT1);
    localparam logic [DW-1:0] PARK_MASK = DW'(1) << PARK_BIT;

    seq_state_e    state_q, state_d;
    logic [FW-1:0] tgt_khz_q, tgt_par_q;
    logic [DW-1:0] div0_q, div1_q, msel_q;
    logic          down_q;

    logic [MSTAT_W-1:0] mstat;
    logic               accept, is_equal, is_down;
    logic               parked_seen, main_seen, dst_zero;

    assign mstat       = bus_rdata[MSTAT_LSB +: MSTAT_W];
    assign parked_seen = bus_ack && (mstat == MSTAT_W'(MSTAT_PARKED));
    assign main_seen   = bus_ack && (mstat == MSTAT_W'(MSTAT_MAIN));
    assign dst_zero    = bus_ack && (bus_rdata == '0);
    assign accept      = (state_q == S_IDLE) && req_valid;
    assign is_equal    = (req_khz == cur_parent_khz);
    assign is_down     = (req_khz < cur_parent_khz);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and mux-select snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_khz_q <= '0;
            tgt_par_q <= '0;
            div0_q    <= '0;
            div1_q    <= '0;
            msel_q    <= '0;
            down_q    <= 1'b0;
        end else begin
            if (accept) begin
                tgt_khz_q <= req_khz;
                tgt_par_q <= req_parent_khz;
                div0_q    <= req_div0;
                div1_q    <= req_div1;
                down_q    <= is_down;
            end
            if (bus_ack && (state_q == S_PARK_RD || state_q == S_REL_RD)) begin
                msel_q <= bus_rdata;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (is_equal)     state_d = S_FINISH;
                    else if (is_down) state_d = S_PARK_RD;
                    else              state_d = S_DIV0_WR;
                end
            end
            S_PARK_RD:   if (bus_ack) state_d = S_PARK_WR;
            S_PARK_WR:   if (bus_ack) state_d = S_PARK_POLL;
            S_PARK_POLL: begin
                if (parked_seen)                  state_d = S_PLL;
                else if (bus_ack && tmo_expired)  state_d = S_ABORT;
            end
            S_PLL: begin
                if (pll_ack)          state_d = down_q ? S_DIV0_WR : S_REL_RD;
                else if (tmo_expired) state_d = S_ABORT;
            end
            S_DIV0_WR:   if (bus_ack) state_d = S_DIV0_POLL;
            S_DIV0_POLL: begin
                if (dst_zero)                     state_d = S_DIV1_WR;
                else if (bus_ack && tmo_expired)  state_d = S_ABORT;
            end
            S_DIV1_WR:   if (bus_ack) state_d = S_DIV1_POLL;
            S_DIV1_POLL: begin
                if (dst_zero)                     state_d = down_q ? S_REL_RD : S_PARK_RD;
                else if (bus_ack && tmo_expired)  state_d = S_ABORT;
            end
            S_REL_RD:    if (bus_ack) state_d = S_REL_WR;
            S_REL_WR:    if (bus_ack) state_d = S_REL_POLL;
            S_REL_POLL: begin
                if (main_seen)                    state_d = S_FINISH;
                else if (bus_ack && tmo_expired)  state_d = S_ABORT;
            end
            S_FINISH:    state_d = S_IDLE;
            S_ABORT:     state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        pll_req   = 1'b0;
        pll_khz   = down_q ? tgt_khz_q : tgt_par_q;
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        err       = (state_q == S_ABORT);
        tmr_run   = 1'b0;
        tmr_clr   = (state_d != state_q);
        unique case (state_q)
            S_PARK_RD, S_REL_RD: begin
                bus_req  = 1'b1;
                bus_addr = A_MSEL;
            end
            S_PARK_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_MSEL;
                bus_wdata = msel_q | PARK_MASK;
            end
            S_REL_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_MSEL;
                bus_wdata = msel_q & ~PARK_MASK;
            end
            S_PARK_POLL, S_REL_POLL: begin
                bus_req  = 1'b1;
                bus_addr = A_MSTAT;
                tmr_run  = 1'b1;
            end
            S_PLL: begin
                pll_req = 1'b1;
                tmr_run = 1'b1;
            end
            S_DIV0_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_DIV0;
                bus_wdata = div0_q;
            end
            S_DIV1_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_DIV1;
                bus_wdata = div1_q;
            end
            S_DIV0_POLL: begin
                bus_req  = 1'b1;
                bus_addr = A_DST0;
                tmr_run  = 1'b1;
            end
            S_DIV1_POLL: begin
                bus_req  = 1'b1;
                bus_addr = A_DST1;
                tmr_run  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpuclk_rate_seq.sv
module cpuclk_rate_seq #(
    parameter int FW      = 32,
    parameter int DW      = 32,
    parameter int AW      = 12,
    parameter int TW      = 16,
    parameter int NUM_ENT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [FW-1:0]         req_khz,
    input  logic [FW-1:0]         req_parent_khz,
    input  logic [DW-1:0]         req_div0,
    input  logic [DW-1:0]         req_div1,
    input  logic [FW-1:0]         cur_parent_khz,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [AW-1:0]         bus_addr,
    output logic [DW-1:0]         bus_wdata,
    input  logic [DW-1:0]         bus_rdata,
    input  logic                  bus_ack,
    output logic                  pll_req,
    output logic [FW-1:0]         pll_khz,
    input  logic                  pll_ack,
    input  logic [TW-1:0]         poll_limit,
    input  logic [NUM_ENT*FW-1:0] table_khz,
    input  logic [FW-1:0]         query_khz,
    output logic [FW-1:0]         rounded_khz
);

    logic tmr_run, tmr_clr, tmo_expired;

    cpuclk_seq_fsm #(.FW(FW), .DW(DW), .AW(AW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_khz        (req_khz),
        .req_parent_khz (req_parent_khz),
        .req_div0       (req_div0),
        .req_div1       (req_div1),
        .cur_parent_khz (cur_parent_khz),
        .bus_rdata      (bus_rdata),
        .bus_ack        (bus_ack),
        .pll_ack        (pll_ack),
        .tmo_expired    (tmo_expired),
        .busy           (busy),
        .done           (done),
        .err            (err),
        .bus_req        (bus_req),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .pll_req        (pll_req),
        .pll_khz        (pll_khz),
        .tmr_run        (tmr_run),
        .tmr_clr        (tmr_clr)
    );

    cpuclk_poll_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clr     (tmr_clr),
        .limit   (poll_limit),
        .expired (tmo_expired)
    );

    cpuclk_freq_round #(.NUM_ENT(NUM_ENT), .FW(FW)) u_round (
        .table_khz   (table_khz),
        .query_khz   (query_khz),
        .rounded_khz (rounded_khz)
    );

endmodule

// File: rtl/cpuclk_rate_seq_chk.sv
module cpuclk_rate_seq_chk #(
    parameter int FW = 32,
    parameter int DW = 32,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack,
    input logic          pll_req,
    input logic [FW-1:0] pll_khz,
    input logic          pll_ack
);

    p_no_done_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_busy_falls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !busy);

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !pll_req));

    p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_write_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_addr == AW'('h000) || bus_addr == AW'('h300) || bus_addr == AW'('h304)));

    p_pll_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> (pll_req || err));

    p_pll_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> $stable(pll_khz));

    p_pll_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_req && bus_req));

endmodule

bind cpuclk_rate_seq cpuclk_rate_seq_chk #(.FW(FW), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .pll_req   (pll_req),
    .pll_khz   (pll_khz),
    .pll_ack   (pll_ack)
);

// File: tb/cpuclk_rate_seq_test.sv
`timescale 1ns/1ps
module cpuclk_rate_seq_test;

    localparam int FW = 32, DW = 32, AW = 12, TW = 16, NE = 8;
    localparam logic [FW-1:0] TBL [NE] = '{32'd1400000, 32'd1200000, 32'd1000000, 32'd800000,
                                           32'd600000,  32'd400000,  32'd200000,  32'd100000};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [FW-1:0] req_khz = '0, req_parent_khz = '0, cur_parent_khz = 32'd800000;
    logic [DW-1:0] req_div0 = '0, req_div1 = '0;
    logic busy, done, err, bus_req, bus_we, pll_req;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_ack = 1'b0, pll_ack = 1'b0;
    logic [FW-1:0] pll_khz, rounded_khz;
    logic [FW-1:0] query_khz = '0;
    logic [TW-1:0] poll_limit = 16'd200;
    logic [NE*FW-1:0] table_khz;

    for (genvar g = 0; g < NE; g++) begin : g_tbl
        assign table_khz[g*FW +: FW] = TBL[g];
    end

    cpuclk_rate_seq #(.FW(FW), .DW(DW), .AW(AW), .TW(TW), .NUM_ENT(NE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_khz(req_khz),
        .req_parent_khz(req_parent_khz), .req_div0(req_div0), .req_div1(req_div1),
        .cur_parent_khz(cur_parent_khz), .busy(busy), .done(done), .err(err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .pll_req(pll_req), .pll_khz(pll_khz),
        .pll_ack(pll_ack), .poll_limit(poll_limit), .table_khz(table_khz),
        .query_khz(query_khz), .rounded_khz(rounded_khz)
    );

    int checks = 0, errors = 0;

    // Model of the clock-control block
    logic [31:0] mux_sel = 32'h0A5C_3007;
    logic [2:0]  mux_stat = 3'd1;
    int mux_tmr = 0, d0_busy = 0, d1_busy = 0, viol = 0;
    bit d0_conf = 1'b0, stuck = 1'b0;
    logic [47:0] ev_log [16];
    int ev_n = 0;

    task automatic log_ev(input logic [3:0] kind, input logic [11:0] a, input logic [31:0] d);
        if (ev_n < 16) ev_log[ev_n] = {kind, a, d};
        ev_n++;
    endtask

    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (mux_tmr > 0) begin
                mux_tmr--;
                if (mux_tmr == 0 && !stuck) mux_stat = mux_sel[16] ? 3'd2 : 3'd1;
            end
            if (d0_busy > 0) d0_busy--;
            if (d1_busy > 0) d1_busy--;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (lat > 0) begin
                    lat--;
                end else begin
                    if (bus_we) begin
                        case (bus_addr)
                            12'h000: begin mux_sel = bus_wdata; mux_stat = 3'd4; mux_tmr = 1 + int'($urandom % 4); end
                            12'h300: begin d0_conf = 1'b0; d0_busy = 1 + int'($urandom % 3); end
                            12'h304: begin if (!d0_conf) viol++; d1_busy = 1 + int'($urandom % 3); end
                            default: viol++;
                        endcase
                        log_ev(4'd1, bus_addr, bus_wdata);
                    end else begin
                        case (bus_addr)
                            12'h000: bus_rdata = mux_sel;
                            12'h200: bus_rdata = ($urandom & ~32'h0007_0000) | ({29'd0, mux_stat} << 16);
                            12'h400: begin bus_rdata = d0_busy; if (d0_busy == 0) d0_conf = 1'b1; end
                            12'h404: bus_rdata = d1_busy;
                            default: begin bus_rdata = '0; viol++; end
                        endcase
                    end
                    bus_ack = 1'b1;
                    lat = int'($urandom % 3);
                end
            end
        end
    end

    // Model of the parent-PLL control port
    initial begin
        int dly;
        dly = 0;
        forever begin
            @(negedge clk);
            if (pll_ack) begin
                pll_ack = 1'b0;
            end else if (pll_req) begin
                if (dly > 0) dly--;
                else begin
                    if (mux_stat != 3'd2) viol++;   // R5: PLL only while parked
                    log_ev(4'd2, 12'h000, pll_khz);
                    cur_parent_khz = pll_khz;
                    pll_ack = 1'b1;
                    dly = int'($urandom % 5);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] round_ref(input logic [FW-1:0] q);
        for (int i = 0; i < NE; i++) if (q >= TBL[i]) return TBL[i];
        return TBL[NE-1];
    endfunction

    logic [47:0] exp_log [8];
    int exp_n;

    function automatic void build_exp(input bit down, input bit equal, input logic [31:0] rate,
                                      input logic [31:0] par, input logic [31:0] d0,
                                      input logic [31:0] d1, input logic [31:0] msel);
        logic [31:0] set_v, clr_v;
        set_v = msel | 32'h0001_0000;
        clr_v = msel & ~32'h0001_0000;
        exp_n = 0;
        if (equal) return;
        if (down) begin
            exp_log[0] = {4'd1, 12'h000, set_v};
            exp_log[1] = {4'd2, 12'h000, rate};
            exp_log[2] = {4'd1, 12'h300, d0};
            exp_log[3] = {4'd1, 12'h304, d1};
        end else begin
            exp_log[0] = {4'd1, 12'h300, d0};
            exp_log[1] = {4'd1, 12'h304, d1};
            exp_log[2] = {4'd1, 12'h000, set_v};
            exp_log[3] = {4'd2, 12'h000, par};
        end
        exp_log[4] = {4'd1, 12'h000, clr_v};
        exp_n = 5;
    endfunction

    task automatic run_req(input logic [31:0] rate, input logic [31:0] par,
                           input logic [31:0] d0, input logic [31:0] d1,
                           input bit inject, input bit expect_err);
        bit equal, down;
        int cyc;
        string tag;
        equal = (rate == cur_parent_khz);
        down  = (rate < cur_parent_khz);
        tag   = equal ? "R1" : (down ? "R2" : "R3");
        build_exp(down, equal, rate, par, d0, d1, mux_sel);
        if (expect_err) exp_n = 1;
        ev_n = 0;
        viol = 0;
        @(negedge clk);
        req_khz = rate; req_parent_khz = par; req_div0 = d0; req_div1 = d1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!(done || err) && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 3) begin
                // R10: strobe while busy carries other values
                req_khz = TBL[0]; req_parent_khz = TBL[0]; req_div0 = 32'hDEAD; req_div1 = 32'hBEEF;
                req_valid = 1'b1;
            end
            if (inject && cyc == 4) req_valid = 1'b0;
        end
        if (expect_err) begin
            chk(err && !done, "R9", "abort flag", {62'd0, done, err}, 64'd1);
        end else begin
            chk(done && !err, tag, "completion", {62'd0, done, err}, 64'd2);
        end
        if (equal) chk(cyc == 1, "R1", "cycles to done", cyc, 1);
        chk(ev_n == exp_n, tag, "event count", ev_n, exp_n);
        for (int i = 0; i < exp_n && i < ev_n; i++)
            chk(ev_log[i] == exp_log[i], (i == 4) ? "R6" : tag, "event", ev_log[i], exp_log[i]);
        chk(viol == 0, "R4", "status-confirm violations", viol, 0);
        if (!equal && !expect_err)
            chk(mux_stat == 3'd1 && !mux_sel[16], "R5", "final mux state", {mux_sel[16], mux_stat}, 1);
        @(negedge clk);
        chk(!busy, "R10", "busy after end", busy, 0);
        repeat (3) @(negedge clk);
        chk(ev_n == exp_n, "R10", "no activity after end", ev_n, exp_n);
    endtask

    initial begin
        void'($urandom(32'd20240121));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err, "R10", "reset flags", {busy, done, err}, 0);
        chk(!bus_req && !pll_req, "R10", "reset requests", {bus_req, pll_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R10", "idle after reset", busy, 0);

        // R8 rounding: directed corners then random queries
        query_khz = 32'd2000000; #1 chk(rounded_khz == TBL[0], "R8", "above max", rounded_khz, TBL[0]);
        query_khz = 32'd600000;  #1 chk(rounded_khz == 32'd600000, "R8", "exact", rounded_khz, 600000);
        query_khz = 32'd999999;  #1 chk(rounded_khz == 32'd800000, "R8", "between", rounded_khz, 800000);
        query_khz = 32'd50;      #1 chk(rounded_khz == TBL[NE-1], "R8", "below min", rounded_khz, TBL[NE-1]);
        for (int i = 0; i < 20; i++) begin
            query_khz = $urandom % 1600000;
            #1 chk(rounded_khz == round_ref(query_khz), "R8", "random", rounded_khz, round_ref(query_khz));
        end

        // Directed: equal, decrease, increase with a strobe while busy
        run_req(32'd800000, 32'd800000, 32'h1, 32'h2, 1'b0, 1'b0);
        run_req(32'd400000, 32'd400000, 32'h0012_3400, 32'h0000_0456, 1'b0, 1'b0);
        run_req(32'd1200000, 32'd1200000, 32'h0077_0011, 32'h0000_0123, 1'b1, 1'b0);

        // Random mix
        for (int k = 0; k < 14; k++) begin
            logic [31:0] r, p;
            r = TBL[$urandom % NE];
            p = ($urandom % 2 == 0) ? r : r * 2;
            run_req(r, p, $urandom, $urandom, ($urandom % 3 == 0), 1'b0);
        end

        // R9: mux status never settles, timeout abort
        stuck = 1'b1;
        poll_limit = 16'd20;
        if (cur_parent_khz <= TBL[NE-1]) run_req(TBL[0], TBL[0], 32'h5, 32'h6, 1'b0, 1'b0);
        run_req(TBL[NE-1], TBL[NE-1], 32'h7, 32'h8, 1'b0, 1'b1);
        stuck = 1'b0;
        mux_tmr = 1;
        poll_limit = 16'd200;
        repeat (4) @(negedge clk);
        run_req(TBL[0], TBL[0], 32'h9, 32'hA, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule